// File: doc/BRIEF.md
# Quadrature encoder position counter

This block keeps a position count from two quadrature inputs, A and B. A two-bit mode selects the counting rule. Mode 0 counts up once per clock. Mode 1 counts both edges of A, and the level of B sets the direction. Mode 2 counts both edges of B, and the level of A sets the direction. Mode 3 counts every edge of both inputs, which gives four counts per encoder cycle. Every count goes through one counter. That counter wraps at a programmable ceiling and keeps a direction flag.

A small register port controls the block. Address 0 holds the count and address 1 holds the ceiling. Address 2 is control: mode in bits [1:0], enable in bit 2, an update request in bit 3 that is used on writes only, and the direction flag in bit 4 that is read only. Before it changes the mode, software clears enable. It then writes the new mode together with the update request, and after that sets enable again.

Top module: `qenc_counter`

## Requirements
- R1: After reset, the count is 0, the direction flag is 0 and the wrap pulse is low. Control reads as 0, meaning mode 0 and enable off. The ceiling is all ones.
- R2: In mode 0 with enable set, the count rises by one on every clock, whatever the encoder inputs do.
- R3: In mode 1, every change of the synchronised A level moves the count by one. The count goes up when the new A level differs from B and down when it equals B. Changes of B alone leave the count unchanged.
- R4: In mode 2, every change of the synchronised B level moves the count by one. The count goes up when the new B level equals A and down when it differs. Changes of A alone leave the count unchanged.
- R5: In mode 3, a change of A alone counts in the same way as in mode 1, and a change of B alone counts in the same way as in mode 2. As a result the count rises by one per edge while A leads B and falls by one per edge while B leads A.
- R6: In mode 3, a sample in which A and B both change is invalid and leaves the count and the direction flag unchanged.
- R7: A count up from a value at or above the ceiling gives 0. A count down from 0 gives the ceiling. Each such wrap raises wrap_o for exactly the clock in which the wrapped value appears.
- R8: The direction flag (control bit 4, and dir_o) becomes 0 after an upward count and 1 after a downward count. It holds its value when no count happens.
- R9: With enable clear, the count does not change on either encoder edges or clocks.
- R10: A write to address 0 loads the count directly. A write to address 1 changes the ceiling at once, so the very next count already uses the new value.
- R11: The mode field of a control write takes effect only when bit 3 of the same write is set. That write also clears the count to 0. A control write without bit 3 changes only enable.
- R12: Each input passes through a two-stage synchroniser. A level change on a pin reaches the count on the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder input A (asynchronous) |
| enc_b | input | 1 | Encoder input B (asynchronous) |
| reg_addr | input | 2 | Register address: 0 count, 1 ceiling, 2 control |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| count_o | output | CNT_W | Current position count |
| dir_o | output | 1 | Direction flag, 1 = last count was downward |
| wrap_o | output | 1 | One-clock pulse on every wrap |

## Verification
In mode 3 the inputs are walked through a forward Gray sequence, then a reverse one, then a step in which both inputs change together. The forward and reverse walks separate the up and down direction rules. The joint change separates a rejected sample from a counted one, and with a ceiling of 5 the walk also crosses both wrap points. In modes 1 and 2 the bench toggles the input that should count and the input that should not, one after the other, which shows which pin carries the step and which carries the direction. Mode 0 is timed over a fixed enable window and from a preset count, so the exact number of clocks and the wrap can be checked. Inputs toggled while enable is clear confirm that the count is frozen.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MODE_CLK = 2'd0,
    MODE_X2A = 2'd1,
    MODE_X2B = 2'd2,
    MODE_X4  = 2'd3
  } qmode_e;

  typedef struct packed {
    logic step;
    logic up;
    logic bad;
  } qstep_t;

  // lvl/chg index 0 is input A, index 1 is input B (new level, change flag)
  function automatic qstep_t qdecode(qmode_e m, logic [1:0] lvl, logic [1:0] chg);
    qstep_t r;
    logic   a_dir;
    logic   b_dir;
    a_dir = lvl[0] ^ lvl[1];
    b_dir = ~(lvl[0] ^ lvl[1]);
    r = '0;
    case (m)
      MODE_CLK: begin
        r.step = 1'b1;
        r.up   = 1'b1;
      end
      MODE_X2A: begin
        r.step = chg[0];
        r.up   = a_dir;
      end
      MODE_X2B: begin
        r.step = chg[1];
        r.up   = b_dir;
      end
      default: begin
        r.bad  = chg[0] & chg[1];
        r.step = (chg[0] ^ chg[1]);
        r.up   = chg[0] ? a_dir : b_dir;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int CH     = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] din,
  output logic [CH-1:0] lvl,
  output logic [CH-1:0] chg
);

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], din[g]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
    assign chg[g] = chain[STAGES-1] ^ prev;
  end

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  qmode_e     mode,
  input  logic [1:0] lvl,
  input  logic [1:0] chg,
  output logic       step,
  output logic       up,
  output logic       bad
);

  qstep_t d;
  always_comb d = qdecode(mode, lvl, chg);
  assign step = d.step;
  assign up   = d.up;
  assign bad  = d.bad;

endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         up,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  input  logic [W-1:0] ceil,
  output logic [W-1:0] cnt,
  output logic         dir,
  output logic         wrap
);

  // returns {wrapped, next value}
  function automatic logic [W:0] advance(logic [W-1:0] c, logic [W-1:0] top, logic go_up);
    if (go_up) begin
      if (c >= top) return {1'b1, {W{1'b0}}};
      return {1'b0, c + 1'b1};
    end
    if (c == '0) return {1'b1, top};
    return {1'b0, c - 1'b1};
  endfunction

  logic [W:0] nxt;
  always_comb nxt = advance(cnt, ceil, up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dir  <= 1'b0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (ld) begin
        cnt <= ld_val;
      end else if (adv) begin
        cnt  <= nxt[W-1:0];
        wrap <= nxt[W];
        dir  <= ~up;
      end
    end
  end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             wrap_o
);

  localparam logic [1:0] A_CNT  = 2'd0;
  localparam logic [1:0] A_CEIL = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam int         CB_UPD = 3;

  logic [CNT_W-1:0] ceil_q;
  logic             enable_q;
  qmode_e           mode_act;

  logic [1:0] in_lvl;
  logic [1:0] in_chg;
  logic       step_raw;
  logic       step_up;
  logic       step_bad;
  logic       step_go;
  logic       cnt_ld;
  logic       cnt_clr;

  qenc_sync #(.CH(2), .STAGES(2)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({enc_b, enc_a}),
    .lvl  (in_lvl),
    .chg  (in_chg)
  );

  qenc_decode i_dec (
    .mode(mode_act),
    .lvl (in_lvl),
    .chg (in_chg),
    .step(step_raw),
    .up  (step_up),
    .bad (step_bad)
  );

  assign step_go = enable_q & step_raw;
  assign cnt_ld  = reg_wr && (reg_addr == A_CNT);
  assign cnt_clr = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CB_UPD];

  qenc_count #(.W(CNT_W)) i_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (step_go),
    .up    (step_up),
    .ld    (cnt_ld),
    .ld_val(reg_wdata),
    .clr   (cnt_clr),
    .ceil  (ceil_q),
    .cnt   (count_o),
    .dir   (dir_o),
    .wrap  (wrap_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_q   <= '1;
      enable_q <= 1'b0;
      mode_act <= MODE_CLK;
    end else if (reg_wr) begin
      if (reg_addr == A_CEIL) ceil_q <= reg_wdata;
      if (reg_addr == A_CTRL) begin
        enable_q <= reg_wdata[2];
        if (reg_wdata[CB_UPD]) mode_act <= qmode_e'(reg_wdata[1:0]);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CNT:  reg_rdata = count_o;
      A_CEIL: reg_rdata = ceil_q;
      A_CTRL: begin
        reg_rdata[1:0] = mode_act;
        reg_rdata[2]   = enable_q;
        reg_rdata[4]   = dir_o;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             enable_q,
  input logic [CNT_W-1:0] ceil_q,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o,
  input logic             wrap_o,
  input logic             step_go,
  input logic             step_up,
  input logic             step_bad
);

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_q && !reg_wr) |=> $stable(count_o));

  // R6
  bad_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_bad && !reg_wr) |=> ($stable(count_o) && $stable(dir_o)));

  // R8
  dir_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !reg_wr) |=> (dir_o == !$past(step_up)));

  // R7
  wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && step_up && (count_o >= ceil_q) && !reg_wr) |=> (count_o == '0 && wrap_o));

  // R7
  wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !step_up && (count_o == '0) && !reg_wr) |=> (count_o == ceil_q && wrap_o));

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_go) |=> !wrap_o);

endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_wr  (reg_wr),
  .enable_q(enable_q),
  .ceil_q  (ceil_q),
  .count_o (count_o),
  .dir_o   (dir_o),
  .wrap_o  (wrap_o),
  .step_go (step_go),
  .step_up (step_up),
  .step_bad(step_bad)
);

// File: tb/test_qenc_counter.sv
`timescale 1ns/1ps
module test_qenc_counter;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enc_a = 1'b0;
  logic         enc_b = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic         reg_wr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] count_o;
  logic         dir_o;
  logic         wrap_o;

  int n_chk = 0;
  int n_fail = 0;
  int wraps = 0;
  int wrap_base;
  logic [W-1:0] rd;

  always #2.5 clk = ~clk;

  qenc_counter #(.CNT_W(W)) i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .count_o(count_o), .dir_o(dir_o), .wrap_o(wrap_o)
  );

  always @(negedge clk) if (wrap_o) wraps++;

  // {a, b, dir, count} after each input step, mode 3, ceiling 5
  localparam logic [18:0] VEC [11] = '{
    {1'b1, 1'b0, 1'b0, 16'd1},
    {1'b1, 1'b1, 1'b0, 16'd2},
    {1'b0, 1'b1, 1'b0, 16'd3},
    {1'b0, 1'b0, 1'b0, 16'd4},
    {1'b1, 1'b0, 1'b0, 16'd5},
    {1'b1, 1'b1, 1'b0, 16'd0},
    {1'b1, 1'b0, 1'b1, 16'd5},
    {1'b0, 1'b0, 1'b1, 16'd4},
    {1'b1, 1'b1, 1'b1, 16'd4},
    {1'b0, 1'b1, 1'b0, 16'd5},
    {1'b0, 1'b0, 1'b0, 16'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic enc(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 wrap", wrap_o, 0);
    rdreg(2'd2, rd); chk("R1 control", rd, 0);
    rdreg(2'd1, rd); chk("R1 ceiling", rd, 16'hFFFF);

    // R2 mode 0: enable window of 10 clock edges
    wr(2'd2, 16'h0004);
    repeat (8) @(negedge clk);
    wr(2'd2, 16'h0000);
    chk("R2 clock count", count_o, 10);

    // R10 preset and immediate ceiling; R7 wrap in mode 0
    wr(2'd1, 16'd3);
    wr(2'd0, 16'd2);
    chk("R10 preset", count_o, 2);
    wrap_base = wraps;
    wr(2'd2, 16'h0004);
    repeat (3) @(negedge clk);
    wr(2'd2, 16'h0000);
    chk("R7 mode0 wrap value", count_o, 3);
    chk("R7 mode0 wrap pulses", wraps - wrap_base, 1);

    // R11 mode 3 with update, then enable
    wr(2'd1, 16'd5);
    wr(2'd2, 16'h000B);
    chk("R11 update clears count", count_o, 0);
    wr(2'd2, 16'h0007);
    wrap_base = wraps;
    // R5 R6 R7 R8 R12 table walk
    for (int i = 0; i < 11; i++) begin
      enc(VEC[i][18], VEC[i][17]);
      chk($sformatf("R5 R6 step %0d count", i), count_o, VEC[i][15:0]);
      chk($sformatf("R8 step %0d dir", i), dir_o, VEC[i][16]);
    end
    chk("R7 x4 wrap pulses", wraps - wrap_base, 3);

    // R11 mode without update bit is not applied
    wr(2'd2, 16'h0001);
    rdreg(2'd2, rd); chk("R11 pending mode", rd, 16'h0003);
    wr(2'd2, 16'h0009);
    rdreg(2'd2, rd); chk("R11 applied mode", rd, 16'h0001);
    wr(2'd1, 16'd100);
    wr(2'd2, 16'h0005);

    // R3 mode 1 (inputs at 00)
    enc(1'b0, 1'b1); chk("R3 B edge ignored", count_o, 0);
    enc(1'b1, 1'b1); chk("R3 A rise down wrap", count_o, 100);
    chk("R8 down dir", dir_o, 1);
    enc(1'b0, 1'b1); chk("R3 A fall up wrap", count_o, 0);
    enc(1'b0, 1'b0); chk("R3 B fall ignored", count_o, 0);
    enc(1'b1, 1'b0); chk("R3 A rise up", count_o, 1);

    // R4 mode 2 (inputs at 10)
    wr(2'd2, 16'h000A);
    wr(2'd2, 16'h0006);
    enc(1'b0, 1'b0); chk("R4 A edge ignored", count_o, 0);
    enc(1'b0, 1'b1); chk("R4 B rise down", count_o, 100);
    enc(1'b0, 1'b0); chk("R4 B fall up wrap", count_o, 0);
    enc(1'b1, 1'b0); chk("R4 A rise ignored", count_o, 0);
    enc(1'b1, 1'b1); chk("R4 B rise up", count_o, 1);
    chk("R8 up dir", dir_o, 0);

    // R9 disabled: edges ignored
    wr(2'd2, 16'h0002);
    enc(1'b1, 1'b0);
    enc(1'b0, 1'b0);
    chk("R9 frozen count", count_o, 1);
    rdreg(2'd0, rd); chk("R9 count register", rd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule